// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block is the coherence engine of one cache in a small multiprocessor whose caches share a bus. The caches use write-back and write-invalidate. The block keeps a direct-mapped array of lines. Each line holds a tag, one data word and a coherence state of Modified, Shared or Invalid. The processor side presents one read or write at a time and gets back a completion pulse, a hit/miss flag and the line's data word. Requests that cannot finish locally ask for the shared bus through a request/grant handshake. Once the grant arrives, the block issues one of four bus commands: read miss, write miss, invalidate or write-back.

At the same time, the block watches transactions that other caches put on the bus. When another cache misses on a line that this cache holds Modified, the block raises an owner-supplies-data flag and drives the word, so that memory stays silent for that transaction. Snooped write misses and invalidates remove this cache's copy. The block decides which command to send only when the grant arrives, using the line state at that moment. An upgrade that was invalidated by a snoop while it waited for the bus therefore becomes a full write miss.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. busReq, busValidOut, cpuDone and snpSupply are low, and the first access to any line misses.
- R2: A read of a Shared or Modified line with a matching tag, or a write of a Modified line with a matching tag, completes with cpuHit=1 and uses the bus not at all. cpuDone is high for exactly one cycle, two clock edges after the edge that accepts cpuReq. On a write, cpuRdata returns the newly written word.
- R3: A read that misses issues command 1 (read miss) at the request address. The line fills with busFillData sampled in that same cycle, ends Shared, and cpuRdata returns the filled word with cpuHit=0.
- R4: A write that misses issues command 2 (write miss) at the request address. The line ends Modified and holds the written word, not the fill data.
- R5: A write to a Shared line with a matching tag issues only command 3 (invalidate), with no fill. The line ends Modified and holds the written word.
- R6: busValidOut is high only in a cycle where busGnt is high. busReq stays high from the lookup until the last transaction of the request. With a grant delay of d cycles, a miss that needs no write-back completes 3+d edges after acceptance.
- R7: A miss whose indexed line is Modified under another tag first issues command 4 (write-back). That transaction carries the victim's address and word. The miss command for the new address follows in a later granted cycle.
- R8: A snooped command 1 that hits a Modified line raises snpSupply and drives the line's word on snpData in the same cycle. The line then becomes Shared, so a later processor write to it issues an invalidate.
- R9: A snooped command 2 that hits a Modified line raises snpSupply with the word. A snooped command 2 or 3 that hits any valid line makes it Invalid, so the next processor access to it misses.
- R10: A snooped command that hits a Shared line with command 1, that misses the tag, or that finds the line Invalid, leaves snpSupply low and leaves the line state unchanged.
- R11: The command is chosen from the line state in the granted cycle. A write upgrade whose Shared line was invalidated by a snoop during the grant wait issues command 2, not command 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request strobe, accepted when the controller is idle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | TAG_W+IDX_W | Line address, with the index in the low bits |
| cpuWdata | input | DATA_W | Write word |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | Request finished without a bus transaction (valid with cpuDone) |
| cpuRdata | output | DATA_W | Line word after the request (valid with cpuDone) |
| busReq | output | 1 | Bus request, held until the last transaction |
| busGnt | input | 1 | Bus grant |
| busValidOut | output | 1 | A transaction is driven this cycle |
| busCmdOut | output | 3 | 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| busAddrOut | output | TAG_W+IDX_W | Transaction address |
| busDataOut | output | DATA_W | Victim word for a write-back |
| busFillData | input | DATA_W | Fill word returned during a miss transaction |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 3 | Snooped command, same encoding as busCmdOut |
| snpAddr | input | TAG_W+IDX_W | Snooped address |
| snpSupply | output | 1 | This cache owns the line and supplies the data |
| snpData | output | DATA_W | Supplied word (valid with snpSupply) |

## Verification
The bench drives a long pseudo-random mix of reads, writes and snoops over three tags that alias on four lines. A reference model predicts the hit flag, the read word, and every bus transaction with its address and data. This exposes a controller that forgets to write back a dirty victim, or that returns fill data for a write miss. Directed steps then catch a Modified line that stays Modified after a snooped read: the next processor write would hit silently instead of invalidating. They also catch a snooped write miss that raises no ownership flag. A long grant delay checks that nothing reaches the bus early. A snoop injected during that delay hits a pending upgrade. A controller that latched its decision before the grant would send an invalidate for a line it no longer holds.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } lineSt_e;

  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_RDMISS = 3'd1,
    BC_WRMISS = 3'd2,
    BC_INVAL  = 3'd3,
    BC_WBACK  = 3'd4
  } busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;   // latch processor request
    logic    lineWr;    // write state and tag of request line
    lineSt_e lineSt;
    logic    dataWr;    // write data word of request line
    logic    takeFill;  // data from bus fill instead of request word
    logic    useVictim; // bus address/data from stored line
    logic    snpWr;     // write state of snooped line
    lineSt_e snpSt;
  } dpStrobe_t;

endpackage

// File: rtl/msi_dpath.sv
module msi_dpath
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  logic [TAG_W+IDX_W-1:0] cpuAddr,
  input  logic                   cpuWe,
  input  logic [DATA_W-1:0]      cpuWdata,
  input  logic [DATA_W-1:0]      busFillData,
  input  logic [TAG_W+IDX_W-1:0] snpAddr,
  output logic                   reqWe,
  output lineSt_e                reqState,
  output logic                   reqTagHit,
  output logic [TAG_W+IDX_W-1:0] busAddrOut,
  output logic [DATA_W-1:0]      busDataOut,
  output logic [DATA_W-1:0]      rdData,
  output lineSt_e                snpState,
  output logic [DATA_W-1:0]      snpData,
  output logic                   snpSameIdx
);
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int LINES  = 1 << IDX_W;

  logic [ADDR_W-1:0] reqAddrQ;
  logic              reqWeQ;
  logic [DATA_W-1:0] reqWdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWeQ    <= 1'b0;
      reqWdataQ <= '0;
    end else if (strb.capture) begin
      reqAddrQ  <= cpuAddr;
      reqWeQ    <= cpuWe;
      reqWdataQ <= cpuWdata;
    end
  end

  logic [IDX_W-1:0]  reqIdx, snpIdx;
  logic [TAG_W-1:0]  reqTag, snpTag;
  logic [DATA_W-1:0] wrWord;

  assign reqIdx = reqAddrQ[IDX_W-1:0];
  assign reqTag = reqAddrQ[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];
  assign wrWord = strb.takeFill ? busFillData : reqWdataQ;

  lineSt_e           stVec   [LINES];
  logic [TAG_W-1:0]  tagVec  [LINES];
  logic [DATA_W-1:0] dataVec [LINES];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    lineSt_e           stQ;
    logic [TAG_W-1:0]  tagQ;
    logic [DATA_W-1:0] dataQ;
    logic              cpuSel, snpSel;

    assign cpuSel = (reqIdx == IDX_W'(g));
    assign snpSel = (snpIdx == IDX_W'(g));

    // processor-side update wins over a snoop to the same line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        stQ <= LN_INV;
      else if (strb.lineWr && cpuSel)   stQ <= strb.lineSt;
      else if (strb.snpWr && snpSel)    stQ <= strb.snpSt;
    end

    always_ff @(posedge clk) begin
      if (strb.lineWr && cpuSel) tagQ  <= reqTag;
      if (strb.dataWr && cpuSel) dataQ <= wrWord;
    end

    assign stVec[g]   = stQ;
    assign tagVec[g]  = tagQ;
    assign dataVec[g] = dataQ;
  end

  assign reqWe      = reqWeQ;
  assign reqState   = stVec[reqIdx];
  assign reqTagHit  = (tagVec[reqIdx] == reqTag);
  assign busAddrOut = strb.useVictim ? {tagVec[reqIdx], reqIdx} : reqAddrQ;
  assign busDataOut = strb.useVictim ? dataVec[reqIdx] : '0;
  assign rdData     = dataVec[reqIdx];

  assign snpState   = (stVec[snpIdx] != LN_INV && tagVec[snpIdx] == snpTag)
                      ? stVec[snpIdx] : LN_INV;
  assign snpData    = dataVec[snpIdx];
  assign snpSameIdx = (snpIdx == reqIdx);

  // a completed fill leaves the request line valid under the request tag
  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineWr && strb.lineSt != LN_INV) |=> (reqState != LN_INV && reqTagHit));

endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      busGnt,
  input  logic      snpValid,
  input  logic [2:0] snpCmd,
  input  logic      reqWe,
  input  lineSt_e   reqState,
  input  logic      reqTagHit,
  input  lineSt_e   snpState,
  input  logic      snpSameIdx,
  output dpStrobe_t strb,
  output logic      cpuDone,
  output logic      cpuHit,
  output logic      busReq,
  output logic      busValidOut,
  output busCmd_e   busCmdOut,
  output logic      snpSupply
);
  typedef enum logic [1:0] {C_IDLE, C_LOOK, C_ARB, C_RESP} ctrlSt_e;

  ctrlSt_e curSt, nxtSt;
  logic    hitQ, hitD;
  logic    lineValid, hitNow, upgrade, victimDirty, granted, lookStall;

  assign lineValid   = (reqState != LN_INV) && reqTagHit;
  assign hitNow      = lineValid && (!reqWe || reqState == LN_MOD);
  assign upgrade     = lineValid && reqWe && reqState == LN_SHR;
  assign victimDirty = !reqTagHit && reqState == LN_MOD;
  assign granted     = busGnt;
  assign lookStall   = snpValid && snpSameIdx;

  always_comb begin
    strb        = '0;
    nxtSt       = curSt;
    hitD        = hitQ;
    busValidOut = 1'b0;
    busCmdOut   = BC_NONE;
    snpSupply   = 1'b0;

    case (curSt)
      C_IDLE: if (cpuReq) begin
        strb.capture = 1'b1;
        nxtSt        = C_LOOK;
      end
      C_LOOK: if (!lookStall) begin
        if (hitNow) begin
          hitD        = 1'b1;
          strb.dataWr = reqWe;
          nxtSt       = C_RESP;
        end else begin
          hitD  = 1'b0;
          nxtSt = C_ARB;
        end
      end
      C_ARB: if (granted) begin
        if (upgrade) begin
          busValidOut = 1'b1;
          busCmdOut   = BC_INVAL;
          strb.lineWr = 1'b1;
          strb.lineSt = LN_MOD;
          strb.dataWr = 1'b1;
          nxtSt       = C_RESP;
        end else if (victimDirty) begin
          busValidOut    = 1'b1;
          busCmdOut      = BC_WBACK;
          strb.useVictim = 1'b1;
          strb.lineWr    = 1'b1;
          strb.lineSt    = LN_INV;
        end else if (hitNow) begin
          strb.dataWr = reqWe;
          nxtSt       = C_RESP;
        end else begin
          busValidOut   = 1'b1;
          busCmdOut     = reqWe ? BC_WRMISS : BC_RDMISS;
          strb.lineWr   = 1'b1;
          strb.lineSt   = reqWe ? LN_MOD : LN_SHR;
          strb.dataWr   = 1'b1;
          strb.takeFill = !reqWe;
          nxtSt         = C_RESP;
        end
      end
      default: nxtSt = C_IDLE;
    endcase

    if (snpValid && snpState != LN_INV) begin
      case (busCmd_e'(snpCmd))
        BC_RDMISS: if (snpState == LN_MOD) begin
          snpSupply  = 1'b1;
          strb.snpWr = 1'b1;
          strb.snpSt = LN_SHR;
        end
        BC_WRMISS: begin
          snpSupply  = (snpState == LN_MOD);
          strb.snpWr = 1'b1;
          strb.snpSt = LN_INV;
        end
        BC_INVAL: begin
          strb.snpWr = 1'b1;
          strb.snpSt = LN_INV;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSt <= C_IDLE;
      hitQ  <= 1'b0;
    end else begin
      curSt <= nxtSt;
      hitQ  <= hitD;
    end
  end

  assign cpuDone = (curSt == C_RESP);
  assign cpuHit  = (curSt == C_RESP) && hitQ;
  assign busReq  = (curSt == C_ARB);

  p_bus_needs_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    busValidOut |-> (busGnt && busReq));
  p_req_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busValidOut) |=> busReq);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);
  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuHit) |-> (!busReq && !$past(busReq)));
  p_inval_upgrades_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busValidOut && busCmdOut == BC_INVAL) |=> (reqState == LN_MOD));
  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValidOut && busCmdOut == BC_WBACK) |=> (busReq && reqState == LN_INV));

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuReq,
  input  logic                   cpuWe,
  input  logic [TAG_W+IDX_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]      cpuWdata,
  output logic                   cpuDone,
  output logic                   cpuHit,
  output logic [DATA_W-1:0]      cpuRdata,
  output logic                   busReq,
  input  logic                   busGnt,
  output logic                   busValidOut,
  output logic [2:0]             busCmdOut,
  output logic [TAG_W+IDX_W-1:0] busAddrOut,
  output logic [DATA_W-1:0]      busDataOut,
  input  logic [DATA_W-1:0]      busFillData,
  input  logic                   snpValid,
  input  logic [2:0]             snpCmd,
  input  logic [TAG_W+IDX_W-1:0] snpAddr,
  output logic                   snpSupply,
  output logic [DATA_W-1:0]      snpData
);
  dpStrobe_t strb;
  lineSt_e   reqState, snpState;
  logic      reqWe, reqTagHit, snpSameIdx;
  busCmd_e   cmdW;

  msi_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .busGnt     (busGnt),
    .snpValid   (snpValid),
    .snpCmd     (snpCmd),
    .reqWe      (reqWe),
    .reqState   (reqState),
    .reqTagHit  (reqTagHit),
    .snpState   (snpState),
    .snpSameIdx (snpSameIdx),
    .strb       (strb),
    .cpuDone    (cpuDone),
    .cpuHit     (cpuHit),
    .busReq     (busReq),
    .busValidOut(busValidOut),
    .busCmdOut  (cmdW),
    .snpSupply  (snpSupply)
  );

  msi_dpath #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cpuAddr    (cpuAddr),
    .cpuWe      (cpuWe),
    .cpuWdata   (cpuWdata),
    .busFillData(busFillData),
    .snpAddr    (snpAddr),
    .reqWe      (reqWe),
    .reqState   (reqState),
    .reqTagHit  (reqTagHit),
    .busAddrOut (busAddrOut),
    .busDataOut (busDataOut),
    .rdData     (cpuRdata),
    .snpState   (snpState),
    .snpData    (snpData),
    .snpSameIdx (snpSameIdx)
  );

  assign busCmdOut = cmdW;

endmodule

// File: tb/msi_line_ctrl_tb_top.sv
module msi_line_ctrl_tb_top;
  localparam int IDX_W = 2;
  localparam int TAG_W = 3;
  localparam int DATA_W = 8;
  localparam int AW = IDX_W + TAG_W;
  localparam int NL = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN;
  logic cpuReq, cpuWe, cpuDone, cpuHit;
  logic [AW-1:0] cpuAddr, busAddrOut, snpAddr;
  logic [DATA_W-1:0] cpuWdata, cpuRdata, busDataOut, busFillData, snpData;
  logic busReq, busGnt, busValidOut, snpValid, snpSupply;
  logic [2:0] busCmdOut, snpCmd;

  always #10 clk = ~clk;

  msi_line_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGnt(busGnt), .busValidOut(busValidOut), .busCmdOut(busCmdOut),
    .busAddrOut(busAddrOut), .busDataOut(busDataOut), .busFillData(busFillData),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr), .snpSupply(snpSupply),
    .snpData(snpData)
  );

  function automatic logic [DATA_W-1:0] fillOf(input logic [AW-1:0] a);
    int v;
    v = int'(a) * 37 + 11;
    return v[DATA_W-1:0];
  endfunction

  assign busFillData = fillOf(busAddrOut);

  int nChecks = 0, nFail = 0;
  int gntDelay = 0, gntCnt = 0;
  int logN = 0;
  int logCmd[16], logAddr[16], logData[16];
  int mSt[NL], mTag[NL], mData[NL];
  int lastLat;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  // arbiter model and bus monitor
  initial begin
    busGnt = 1'b0;
    forever begin
      @(negedge clk);
      if (busReq) begin
        busGnt = (gntCnt >= gntDelay);
        gntCnt++;
      end else begin
        busGnt = 1'b0;
        gntCnt = 0;
      end
      #1;
      if (busValidOut && logN < 16) begin
        logCmd[logN]  = int'(busCmdOut);
        logAddr[logN] = int'(busAddrOut);
        logData[logN] = int'(busDataOut);
        logN++;
      end
    end
  end

  task automatic doCpu(input bit we, input int addr, input int wdata, input int gd);
    int idx, tag, expN, expRd;
    bit expHit;
    int eCmd[2], eAddr[2], eData[2];
    string rq;
    idx = addr % NL;
    tag = addr / NL;
    gntDelay = gd;
    logN = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = AW'(addr); cpuWdata = DATA_W'(wdata);
    @(negedge clk);
    cpuReq = 1'b0;
    lastLat = 1;
    while (!cpuDone && lastLat < 60) begin
      @(negedge clk);
      lastLat++;
    end
    expN = 0;
    if (mSt[idx] != 0 && mTag[idx] == tag && (!we || mSt[idx] == 2)) begin
      expHit = 1'b1; rq = "R2";
      if (we) mData[idx] = wdata;
    end else if (mSt[idx] == 1 && mTag[idx] == tag && we) begin
      expHit = 1'b0; rq = "R5";
      eCmd[0] = 3; eAddr[0] = addr; eData[0] = -1; expN = 1;
      mSt[idx] = 2; mData[idx] = wdata;
    end else begin
      expHit = 1'b0; rq = we ? "R4" : "R3";
      if (mSt[idx] == 2) begin
        rq = "R7";
        eCmd[0] = 4; eAddr[0] = mTag[idx] * NL + idx; eData[0] = mData[idx]; expN = 1;
      end
      eCmd[expN] = we ? 2 : 1; eAddr[expN] = addr; eData[expN] = -1; expN++;
      mTag[idx] = tag; mSt[idx] = we ? 2 : 1;
      mData[idx] = we ? wdata : int'(fillOf(AW'(addr)));
    end
    expRd = mData[idx];
    chk(rq, "done", int'(cpuDone), 1);
    chk(rq, "hit", int'(cpuHit), int'(expHit));
    chk(rq, "rdata", int'(cpuRdata), expRd);
    if (expHit) chk("R2", "hit latency", lastLat, 2);
    chk(rq, "bus transaction count", logN, expN);
    for (int k = 0; k < expN; k++) begin
      if (k < logN) begin
        chk(rq, "bus command", logCmd[k], eCmd[k]);
        chk(rq, "bus address", logAddr[k], eAddr[k]);
        if (eData[k] >= 0) chk(rq, "write-back data", logData[k], eData[k]);
      end
    end
  endtask

  task automatic doSnp(input int cmd, input int addr);
    int idx, tag;
    bit hit, expSup;
    string rq;
    idx = addr % NL;
    tag = addr / NL;
    hit = (mSt[idx] != 0 && mTag[idx] == tag);
    expSup = hit && mSt[idx] == 2 && (cmd == 1 || cmd == 2);
    if (expSup && cmd == 1)                rq = "R8";
    else if (hit && (cmd == 2 || cmd == 3)) rq = "R9";
    else                                    rq = "R10";
    @(negedge clk);
    snpValid = 1'b1; snpCmd = 3'(cmd); snpAddr = AW'(addr);
    #2;
    chk(rq, "snoop supply", int'(snpSupply), int'(expSup));
    if (expSup) chk(rq, "snoop data", int'(snpData), mData[idx]);
    @(negedge clk);
    snpValid = 1'b0;
    if (hit) begin
      if (cmd == 1 && mSt[idx] == 2) mSt[idx] = 1;
      else if (cmd == 2 || cmd == 3) mSt[idx] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int lfsr;
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    snpValid = 1'b0; snpCmd = '0; snpAddr = '0;
    for (int i = 0; i < NL; i++) begin mSt[i] = 0; mTag[i] = 0; mData[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busReq after reset", int'(busReq), 0);
    chk("R1", "busValidOut after reset", int'(busValidOut), 0);
    chk("R1", "cpuDone after reset", int'(cpuDone), 0);
    doSnp(1, 0);
    for (int i = 0; i < NL; i++) begin
      doCpu(1'b0, i + NL, 0, 0);
      chk("R1", "first access hit", int'(cpuHit), 0);
    end

    // R2, R5: read miss then hit, upgrade, write hit
    doCpu(1'b0, 1, 0, 0);
    doCpu(1'b0, 1, 0, 0);
    doCpu(1'b1, 1, 8'h33, 0);
    chk("R5", "upgrade command", logCmd[0], 3);
    doCpu(1'b1, 1, 8'h44, 0);
    // R8: snooped read of dirty line, then a write must invalidate
    doSnp(1, 1);
    doCpu(1'b1, 1, 8'h55, 1);
    chk("R8", "write after supply issues invalidate", logCmd[0], 3);
    // R9: snooped write miss on dirty line
    doSnp(2, 1);
    doCpu(1'b0, 1, 0, 0);
    chk("R9", "access after snooped write miss hit", int'(cpuHit), 0);
    // R4, R7: write miss then conflicting read with write-back
    doCpu(1'b1, 2, 8'h66, 0);
    doCpu(1'b0, 2 + NL, 0, 2);
    chk("R7", "write-back first", logCmd[0], 4);
    // R10, R9: snoops on a shared line
    doSnp(1, 2 + NL);
    doSnp(3, 2 + NL);
    doCpu(1'b0, 2 + NL, 0, 0);
    // R6: grant wait latency
    doCpu(1'b0, 3 + 2 * NL, 0, 4);
    chk("R6", "grant wait latency", lastLat, 7);
    // R11: upgrade invalidated while waiting for grant
    doCpu(1'b0, 0, 0, 0);
    fork
      doCpu(1'b1, 0, 8'h5A, 6);
      begin
        repeat (3) @(negedge clk);
        doSnp(3, 0);
      end
    join
    chk("R11", "command after lost upgrade", logCmd[0], 2);

    // pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      int r, op, a;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0);
      r = lfsr;
      op = r % 5;
      a = ((r / 5) % 3) * NL + ((r / 16) % NL);
      if (op < 2)       doCpu(1'b0, a, 0, (r / 64) % 3);
      else if (op < 4)  doCpu(1'b1, a, (r / 8) % 256, (r / 64) % 3);
      else              doSnp(1 + (r / 128) % 3, a);
    end
    finishRun();
  end

endmodule